// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Break Handling

This block recovers characters from an asynchronous serial line. A shared oversampling strobe (`tick`, sixteen pulses per bit time) paces it. The line is first brought into the clock domain through a two-stage synchroniser. A falling edge is confirmed half a bit later, and every later bit is sampled at its centre. The configuration sets the character length (5 to 8 bits) and whether a parity bit is present. It also sets odd or even parity and whether the frame has one or two stop bits. Each finished character is handed to a downstream queue through a one-cycle `out_valid` strobe. The strobe carries the data together with parity-error, framing-error and break flags.

A stop bit that reads low raises a framing error. The receiver then takes that low level as the start bit of the next frame. It confirms the start bit with one more sample and collects the following bits as a new character.

A frame that is low from start to stop is treated differently. The receiver holds that character back until it is clear whether the line returns high before a full frame time has passed. If the line stays low longer than one complete frame, the receiver delivers exactly one all-zero break character. It then ignores the line until the line has been high for half a bit time.

Top module: `uart_brk_rx`

## Requirements
- R1: While `rst` is high and after reset with the line idle high, `out_valid` stays 0 and no character is delivered.
- R2: Data bits are received least significant bit first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `out_data` above the selected length read 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0, the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd` = 1 they must hold an odd number. `out_perr` is 1 when this does not hold. `out_perr` is always 0 when `cfg_par_en` is 0.
- R4: A character whose first stop-bit sample reads 0 is delivered with `out_ferr` = 1, unless all of its bits were 0 (see R8). A character whose first stop-bit sample reads 1 has `out_ferr` = 0.
- R5: After a framing error, the low stop bit is taken as the start bit of a new frame. The following bits are received as the next character.
- R6: A low pulse shorter than half a bit time (8 ticks) on an idle line starts no character.
- R7: If the line stays low for more than 16 × (1 + data bits + parity bits + stop bits) ticks, exactly one character is delivered for the whole low period. That character has `out_data` = 0, `out_brk` = 1, `out_ferr` = 1 and `out_perr` = 0.
- R8: A frame that is low in every bit, including its first stop sample, and that ends before the break limit is delivered only once the line returns high. It is delivered with `out_data` = 0, `out_ferr` = 1, `out_brk` = 0 and `out_perr` as defined in R3.
- R9: After a break character, no character is delivered until the line has been high for 8 consecutive ticks. Frames received after that are delivered normally.
- R10: `out_valid` is a single-cycle pulse, once per delivered character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| out_valid | output | 1 | One-cycle strobe for a received character |
| out_data | output | 8 | Received character, zero-extended |
| out_perr | output | 1 | Parity error flag for this character |
| out_ferr | output | 1 | Framing error flag for this character |
| out_brk | output | 1 | Break flag for this character |

## Verification
Two functions can meet on the same sample: the framing-error decision on a low stop bit, and the break low-time count, which is still running across that same stop sample. The bench provokes this with all-low frames. Some of these frames release the line a few ticks after the stop sample, and the bench expects one framing-error character with no break flag. Others hold the line low past the frame limit, and the bench expects exactly one break character in place of the framing-error character and then silence until the mark period has passed. Character counts are taken between stimulus phases, so a duplicated or missing delivery is caught.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    localparam int OSR       = 16;
    localparam int HALF      = OSR / 2;
    localparam int CW        = $clog2(OSR);
    localparam int MAXBITS   = 8;
    localparam int MAX_FRAME = OSR * (1 + MAXBITS + 1 + 2);
    localparam int LCW       = $clog2(MAX_FRAME + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW, S_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [MAXBITS-1:0] data;
        logic               perr;
        logic               ferr;
        logic               brk;
    } rx_char_t;

    // ticks in one whole frame: start + (5+len) data + parity + stops
    function automatic logic [LCW-1:0] frame_ticks(rx_cfg_t c);
        return LCW'(OSR * (7 + int'(c.len) + int'(c.par_en) + int'(c.two_stop)));
    endfunction

    function automatic logic [MAXBITS-1:0] len_mask(logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det
    import uart_brk_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           line,
    input  logic [LCW-1:0] limit,
    output logic           brk_lvl,
    output logic           mark_half
);
    logic [LCW-1:0] low_cnt;
    logic [CW-1:0]  hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
        end else if (tick) begin
            if (!line) begin
                hi_cnt <= '0;
                if (low_cnt < limit) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
                if (hi_cnt != CW'(HALF)) hi_cnt <= hi_cnt + 1'b1;
            end
        end
    end

    assign brk_lvl   = (low_cnt >= limit);
    assign mark_half = (hi_cnt == CW'(HALF));

    // R7: the break level can only come up after a low sample
    p_brk_low_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_lvl) |-> $past(!line));
    // R9: the mark period can only complete after a high sample
    p_mark_high_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_half) |-> $past(line));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_perr,
    output logic       out_ferr,
    output logic       out_brk
);
    rx_cfg_t            cfg;
    rx_state_e          state;
    rx_char_t           out_char;
    logic               rxs, brk_lvl, mark_half, pbit, any_one, perr_calc;
    logic [CW-1:0]      cnt;
    logic [2:0]         bidx, last_idx;
    logic [MAXBITS-1:0] dreg;
    logic               bit_end;

    assign cfg       = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                         two_stop: cfg_two_stop};
    assign last_idx  = {1'b0, cfg.len} + 3'd4;
    assign bit_end   = (cnt == CW'(OSR - 1));
    assign perr_calc = cfg.par_en & ((^dreg ^ pbit) != cfg.par_odd);

    uart_brk_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rx_in), .dout(rxs)
    );

    uart_brk_det u_det (
        .clk(clk), .rst(rst), .tick(tick), .line(rxs),
        .limit(frame_ticks(cfg)), .brk_lvl(brk_lvl), .mark_half(mark_half)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            dreg      <= '0;
            pbit      <= 1'b0;
            any_one   <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: if (!rxs) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                    S_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            if (!rxs) begin
                                state   <= S_DATA;
                                bidx    <= '0;
                                dreg    <= '0;
                                pbit    <= 1'b0;
                                any_one <= 1'b0;
                            end else begin
                                state <= S_IDLE;  // glitch
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (bit_end) begin
                            dreg[bidx] <= rxs;
                            any_one    <= any_one | rxs;
                            if (bidx == last_idx)
                                state <= cfg.par_en ? S_PAR : S_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end
                    end
                    S_PAR: begin
                        cnt <= cnt + 1'b1;
                        if (bit_end) begin
                            pbit    <= rxs;
                            any_one <= any_one | rxs;
                            state   <= S_STOP;
                        end
                    end
                    S_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (bit_end) begin
                            if (rxs) begin
                                out_valid <= 1'b1;
                                out_char  <= '{data: dreg, perr: perr_calc, ferr: 1'b0, brk: 1'b0};
                                state     <= S_IDLE;
                            end else if (any_one) begin
                                out_valid <= 1'b1;
                                out_char  <= '{data: dreg, perr: perr_calc, ferr: 1'b1, brk: 1'b0};
                                state     <= S_START;        // bad stop becomes a start bit
                                cnt       <= CW'(HALF - 1);  // confirm it on the next tick
                            end else begin
                                state <= S_BRKW;
                            end
                        end
                    end
                    S_BRKW: begin
                        if (brk_lvl) begin
                            out_valid <= 1'b1;
                            out_char  <= '{data: '0, perr: 1'b0, ferr: 1'b1, brk: 1'b1};
                            state     <= S_HOLD;
                        end else if (rxs) begin
                            out_valid <= 1'b1;
                            out_char  <= '{data: dreg, perr: perr_calc, ferr: 1'b1, brk: 1'b0};
                            state     <= S_IDLE;
                        end
                    end
                    S_HOLD: if (mark_half) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign out_data = out_char.data;
    assign out_perr = out_char.perr;
    assign out_ferr = out_char.ferr;
    assign out_brk  = out_char.brk;

    // R10: delivery strobe lasts one cycle
    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R7: a break character is all zero and carries a framing error
    p_brk_char_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_brk) |-> (out_data == '0 && out_ferr && !out_perr));
    // R2: nothing above the configured length
    p_len_mask_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~len_mask(cfg_len)) == '0));
    // R3: no parity error without a parity bit
    p_noperr_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cfg_par_en) |-> !out_perr);
    // R9: silent while waiting for the mark period
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && $past(state) == S_HOLD) |-> !out_valid);
endmodule

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       out_valid, out_perr, out_ferr, out_brk;
    logic [7:0] out_data;

    int nchk = 0, nerr = 0, got_n = 0;
    bit done = 0;
    logic [7:0] cap_d [64];
    logic       cap_p [64], cap_f [64], cap_b [64];

    always #4 clk = ~clk;

    uart_brk_rx u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .out_valid(out_valid), .out_data(out_data),
        .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            cap_d[got_n % 64] = out_data;
            cap_p[got_n % 64] = out_perr;
            cap_f[got_n % 64] = out_ferr;
            cap_b[got_n % 64] = out_brk;
            got_n = got_n + 1;
        end
    end

    task automatic check_eq(input string req, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic check_cap(input string req, input int k, input logic [7:0] d,
                             input logic p, input logic f, input logic b);
        check_eq(req, "data", int'(cap_d[k % 64]), int'(d));
        check_eq(req, "perr", int'(cap_p[k % 64]), int'(p));
        check_eq(req, "ferr", int'(cap_f[k % 64]), int'(f));
        check_eq(req, "brk",  int'(cap_b[k % 64]), int'(b));
    endtask

    function automatic logic [7:0] msk();
        return 8'hFF >> (2'd3 - cfg_len);
    endfunction

    function automatic logic good_par(input logic [7:0] d);
        return (^(d & msk())) ^ cfg_par_odd;
    endfunction

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic hold_line(input logic v, input int n);
        rx_in = v;
        repeat (n) one_tick();
    endtask

    task automatic send_tail(input logic [7:0] d, input logic bad, input logic stop_lvl,
                             input int stop_ticks);
        for (int i = 0; i < 5 + int'(cfg_len); i++) hold_line(d[i], 16);
        if (cfg_par_en) hold_line(good_par(d) ^ bad, 16);
        hold_line(stop_lvl, stop_ticks);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad, input logic stop_lvl,
                              input int stop_ticks);
        hold_line(1'b0, 16);
        send_tail(d, bad, stop_lvl, stop_ticks);
    endtask

    task automatic set_cfg(input int l, input int pe, input int po, input int ts);
        cfg_len = 2'(l); cfg_par_en = 1'(pe); cfg_par_odd = 1'(po); cfg_two_stop = 1'(ts);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] d;
        logic exp_p;
        repeat (4) @(negedge clk);
        check_eq("R1", "valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        hold_line(1'b1, 40);
        check_eq("R1", "chars after reset", got_n, 0);

        // R2 R3 R10: sweep of every configuration
        for (int l = 0; l < 4; l++)
            for (int pe = 0; pe < 2; pe++)
                for (int po = 0; po < 2; po++)
                    for (int ts = 0; ts < 2; ts++) begin
                        set_cfg(l, pe, po, ts);
                        hold_line(1'b1, 32);
                        for (int k = 0; k < 4; k++) begin
                            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'hA5 + 37 * (k + l));
                            exp_p = (pe == 1) && (k == 2);
                            base = got_n;
                            send_frame(d, exp_p, 1'b1, 16 * (1 + ts));
                            hold_line(1'b1, 24);
                            check_eq("R10", "one char per frame", got_n - base, 1);
                            check_eq("R2", "data", int'(cap_d[base % 64]), int'(d & msk()));
                            check_eq("R3", "perr", int'(cap_p[base % 64]), int'(exp_p));
                            check_eq("R4", "no ferr", int'(cap_f[base % 64]), 0);
                        end
                    end

        // R6: glitch
        set_cfg(3, 1, 0, 0);
        hold_line(1'b1, 32);
        base = got_n;
        hold_line(1'b0, 4);
        hold_line(1'b1, 40);
        check_eq("R6", "glitch chars", got_n - base, 0);
        send_frame(8'h96, 1'b0, 1'b1, 16);
        hold_line(1'b1, 24);
        check_eq("R6", "char after glitch", got_n - base, 1);
        check_cap("R6", base, 8'h96, 1'b0, 1'b0, 1'b0);

        // R4 R5: framing error followed by a line held high
        for (int pe = 0; pe < 2; pe++) begin
            set_cfg(2, pe, 0, 0);
            hold_line(1'b1, 32);
            base = got_n;
            send_frame(8'hA5, 1'b0, 1'b0, 16);
            hold_line(1'b1, 16 * 12);
            check_eq("R4", "chars after bad stop", got_n - base, 2);
            check_cap("R4", base, 8'hA5 & msk(), 1'b0, 1'b1, 1'b0);
            check_cap("R5", base + 1, msk(), cfg_par_en && (good_par(msk()) != 1'b1), 1'b0, 1'b0);
        end

        // R5: bad stop bit is the start of a real frame
        set_cfg(3, 1, 1, 0);
        hold_line(1'b1, 32);
        base = got_n;
        hold_line(1'b0, 16);
        send_tail(8'h5B, 1'b0, 1'b0, 16);
        send_tail(8'h3C, 1'b0, 1'b1, 16);
        hold_line(1'b1, 32);
        check_eq("R5", "resync chars", got_n - base, 2);
        check_cap("R5", base, 8'h5B, 1'b0, 1'b1, 1'b0);
        check_cap("R5", base + 1, 8'h3C, 1'b0, 1'b0, 1'b0);

        // R8: all-low frame released before the break limit
        set_cfg(3, 1, 0, 0);
        hold_line(1'b1, 32);
        base = got_n;
        send_frame(8'h00, 1'b0, 1'b0, 12);
        check_eq("R8", "held while low", got_n - base, 0);
        hold_line(1'b1, 40);
        check_eq("R8", "released", got_n - base, 1);
        check_cap("R8", base, 8'h00, 1'b0, 1'b1, 1'b0);

        // R7 R9: break, short marks, then recovery
        for (int c = 0; c < 2; c++) begin
            if (c == 0) set_cfg(3, 1, 0, 0); else set_cfg(0, 0, 1, 1);
            hold_line(1'b1, 32);
            base = got_n;
            hold_line(1'b0, 16 * (7 + int'(cfg_len) + int'(cfg_par_en) + int'(cfg_two_stop)) + 40);
            check_eq("R7", "break chars", got_n - base, 1);
            check_cap("R7", base, 8'h00, 1'b0, 1'b1, 1'b1);
            hold_line(1'b1, 4);
            hold_line(1'b0, 40);
            hold_line(1'b1, 5);
            hold_line(1'b0, 30);
            check_eq("R9", "silent after short marks", got_n - base, 1);
            hold_line(1'b1, 40);
            send_frame(8'h6D, 1'b0, 1'b1, 32);
            hold_line(1'b1, 24);
            check_eq("R9", "resumed", got_n - base, 2);
            check_cap("R9", base + 1, 8'h6D & msk(), 1'b0, 1'b0, 1'b0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule